// File: doc/BRIEF.md
# Trace-Cache Micro-Op Fetch Sequencer

This block decides where the next group of decoded micro-operations is read from a trace cache. It has its own uop fetch pointer, kept apart from the pointer that steers macroinstruction prefetch. Each cycle the pointer is presented on `fetch_addr`. The trace-cache tag logic answers in the same cycle with a hit flag. On a hit it also reports whether the group holds a uop branch and gives that branch's address. A group with no branch moves the pointer forward by one group step. A group with a branch has its branch address looked up in a small direct-mapped branch target buffer. Each entry of that buffer holds a 2-bit saturating confidence counter, and the entry's target is followed only when the counter predicts taken.

A trace-cache miss parks the sequencer. While it is parked, the missed address is driven out as a refill request toward the L2 side, fetching is suppressed and the pointer is held until `refill_done` is pulsed. The fetch is then retried at the same address. A resolve port trains the buffer from executed branches. A redirect port, used for mispredictions and exceptions, overrides every other source of the next pointer and cancels any refill that is pending.

Top module: `uop_fetch_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fetch_addr` equals `start_addr`, `fetch_valid` is 1 and `refill_req` is 0. Every buffer entry is invalid, so the first branch after reset is predicted not-taken.
- R2: When `fetch_valid` and `tc_hit` are 1, `grp_has_br` is 0 and there is no redirect, the next `fetch_addr` is the current one plus GRP_STEP, modulo 2^AW.
- R3: When the fetched group hits and holds a branch whose buffer entry is valid, has a matching tag and has a counter of 2 or more, the next `fetch_addr` is that entry's target.
- R4: When the fetched group hits and holds a branch that misses in the buffer, or whose counter is 0 or 1, the pointer advances sequentially as in R2.
- R5: When `fetch_valid` is 1 and `tc_hit` is 0 with no redirect, the next cycle shows `refill_req` = 1, `fetch_valid` = 0 and `refill_addr` equal to the missed address. This state holds until a cycle with `refill_done` = 1. After that cycle `fetch_valid` returns to 1 at the same address.
- R6: `redir_valid` = 1 makes the next `fetch_addr` equal to `redir_addr` with `fetch_valid` = 1, whatever the other inputs and the refill state are.
- R7: A resolve (`res_valid` = 1) whose address misses in the buffer writes that entry with the resolve tag and target. The counter is set to 2 if `res_taken` is 1 and to 1 otherwise.
- R8: A resolve whose address hits moves the counter up by one when taken and down by one when not taken, saturating at 3 and 0. The target is replaced only when the resolve is taken.
- R9: The buffer entry is selected by the address bits below log2(ENTRIES). The remaining upper bits are the tag, so a resolve to a different tag with the same index replaces the entry.
- R10: While a refill is pending, `tc_hit`, `grp_has_br` and `grp_br_addr` have no effect on the pointer. Resolves keep training the buffer during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | AW | Pointer value loaded at reset |
| tc_hit | input | 1 | Trace-cache tag compare result for `fetch_addr` |
| grp_has_br | input | 1 | Fetched group holds a uop branch |
| grp_br_addr | input | AW | Address of that branch uop |
| res_valid | input | 1 | Branch resolve strobe |
| res_addr | input | AW | Resolved branch address |
| res_target | input | AW | Resolved branch target |
| res_taken | input | 1 | Resolved branch outcome |
| redir_valid | input | 1 | Pointer redirect strobe |
| redir_addr | input | AW | Redirect address |
| refill_done | input | 1 | L2 refill of the missed address has finished |
| fetch_valid | output | 1 | `fetch_addr` is being fetched this cycle |
| fetch_addr | output | AW | Current uop fetch pointer |
| refill_req | output | 1 | Refill request outstanding |
| refill_addr | output | AW | Address to refill |

## Verification
The bench builds the block with AW = 12, ENTRIES = 4 and GRP_STEP = 2. With four entries, a small pool of branch addresses drawn at random lands on the same index with different tags, so replacement (R9) happens often. The counters move through their full range and saturate within a few resolves. The 12-bit pointer lets a directed redirect to the top of the address space show the sequential step wrapping to zero.

// File: rtl/uopf_pkg.sv
package uopf_pkg;

    typedef enum logic [0:0] {
        SEQ_FETCH  = 1'b0,
        SEQ_REFILL = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        NXT_STEP  = 2'd0,
        NXT_BTB   = 2'd1,
        NXT_HOLD  = 2'd2,
        NXT_REDIR = 2'd3
    } nxt_src_e;

    typedef logic [1:0] conf_t;

    localparam conf_t CONF_MAX      = 2'd3;
    localparam conf_t CONF_MIN      = 2'd0;
    localparam conf_t CONF_TAKEN_TH = 2'd2;
    localparam conf_t CONF_NEW_T    = 2'd2;
    localparam conf_t CONF_NEW_NT   = 2'd1;

    function automatic conf_t conf_train(conf_t c, logic taken);
        conf_t r;
        if (taken) r = (c == CONF_MAX) ? c : c + 2'd1;
        else       r = (c == CONF_MIN) ? c : c - 2'd1;
        return r;
    endfunction

    function automatic logic conf_says_taken(conf_t c);
        return c >= CONF_TAKEN_TH;
    endfunction

    function automatic conf_t conf_initial(logic taken);
        return taken ? CONF_NEW_T : CONF_NEW_NT;
    endfunction

endpackage

// File: rtl/uopf_btb.sv
module uopf_btb
    import uopf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ENTRIES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic          lk_taken,
    output logic [AW-1:0] lk_target,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_addr,
    input  logic [AW-1:0] upd_target,
    input  logic          upd_taken
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = AW - IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [AW-1:0]    tgt;
        conf_t            conf;
    } btb_ent_t;

    btb_ent_t ent_arr [ENTRIES];

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] upd_idx;
    logic [TAG_W-1:0] upd_tag;
    btb_ent_t         lk_ent;
    btb_ent_t         upd_old;
    btb_ent_t         upd_new;
    logic             upd_match;

    assign lk_idx  = lk_addr[IDX_W-1:0];
    assign lk_tag  = lk_addr[AW-1:IDX_W];
    assign upd_idx = upd_addr[IDX_W-1:0];
    assign upd_tag = upd_addr[AW-1:IDX_W];

    // read side: one entry, tag compare, confidence threshold
    always_comb begin
        lk_ent    = ent_arr[lk_idx];
        lk_hit    = lk_ent.vld && (lk_ent.tag == lk_tag);
        lk_taken  = lk_hit && conf_says_taken(lk_ent.conf);
        lk_target = lk_ent.tgt;
    end

    // write side: train a matching entry or overwrite the slot
    always_comb begin
        upd_old   = ent_arr[upd_idx];
        upd_match = upd_old.vld && (upd_old.tag == upd_tag);
        if (upd_match) begin
            upd_new      = upd_old;
            upd_new.conf = conf_train(upd_old.conf, upd_taken);
            if (upd_taken) begin
                upd_new.tgt = upd_target;
            end
        end else begin
            upd_new.vld  = 1'b1;
            upd_new.tag  = upd_tag;
            upd_new.tgt  = upd_target;
            upd_new.conf = conf_initial(upd_taken);
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        btb_ent_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (upd_valid && (upd_idx == IDX_W'(e))) begin
                ent_q <= upd_new;
            end
        end
        assign ent_arr[e] = ent_q;
    end

endmodule

// File: rtl/uopf_ctl.sv
module uopf_ctl
    import uopf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tc_hit,
    input  logic       grp_has_br,
    input  logic       btb_taken,
    input  logic       redir_valid,
    input  logic       refill_done,
    output seq_state_e state_q,
    output nxt_src_e   nxt_src
);
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        nxt_src = NXT_HOLD;
        if (redir_valid) begin
            nxt_src = NXT_REDIR;
            state_d = SEQ_FETCH;
        end else if (state_q == SEQ_FETCH) begin
            if (!tc_hit) begin
                nxt_src = NXT_HOLD;
                state_d = SEQ_REFILL;
            end else if (grp_has_br && btb_taken) begin
                nxt_src = NXT_BTB;
            end else begin
                nxt_src = NXT_STEP;
            end
        end else begin
            nxt_src = NXT_HOLD;
            if (refill_done) begin
                state_d = SEQ_FETCH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_FETCH;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/uopf_ptr.sv
module uopf_ptr
    import uopf_pkg::*;
#(
    parameter int AW       = 32,
    parameter int GRP_STEP = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] start_addr,
    input  nxt_src_e      nxt_src,
    input  logic [AW-1:0] btb_target,
    input  logic [AW-1:0] redir_addr,
    output logic [AW-1:0] ptr_q
);
    localparam logic [AW-1:0] STEP = AW'(GRP_STEP);

    logic [AW-1:0] ptr_d;

    always_comb begin
        unique case (nxt_src)
            NXT_STEP:  ptr_d = ptr_q + STEP;
            NXT_BTB:   ptr_d = btb_target;
            NXT_REDIR: ptr_d = redir_addr;
            default:   ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= start_addr;
        else     ptr_q <= ptr_d;
    end

endmodule

// File: rtl/uop_fetch_seq.sv
module uop_fetch_seq
    import uopf_pkg::*;
#(
    parameter int AW       = 32,
    parameter int ENTRIES  = 16,
    parameter int GRP_STEP = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] start_addr,
    input  logic          tc_hit,
    input  logic          grp_has_br,
    input  logic [AW-1:0] grp_br_addr,
    input  logic          res_valid,
    input  logic [AW-1:0] res_addr,
    input  logic [AW-1:0] res_target,
    input  logic          res_taken,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_addr,
    input  logic          refill_done,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    output logic          refill_req,
    output logic [AW-1:0] refill_addr
);
    seq_state_e    state_q;
    nxt_src_e      nxt_src;
    logic          btb_hit;
    logic          btb_taken;
    logic [AW-1:0] btb_target;
    logic [AW-1:0] ptr_q;

    uopf_btb #(.AW(AW), .ENTRIES(ENTRIES)) u_btb (
        .clk        (clk),
        .rst        (rst),
        .lk_addr    (grp_br_addr),
        .lk_hit     (btb_hit),
        .lk_taken   (btb_taken),
        .lk_target  (btb_target),
        .upd_valid  (res_valid),
        .upd_addr   (res_addr),
        .upd_target (res_target),
        .upd_taken  (res_taken)
    );

    uopf_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .tc_hit      (tc_hit),
        .grp_has_br  (grp_has_br),
        .btb_taken   (btb_taken && btb_hit),
        .redir_valid (redir_valid),
        .refill_done (refill_done),
        .state_q     (state_q),
        .nxt_src     (nxt_src)
    );

    uopf_ptr #(.AW(AW), .GRP_STEP(GRP_STEP)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .start_addr (start_addr),
        .nxt_src    (nxt_src),
        .btb_target (btb_target),
        .redir_addr (redir_addr),
        .ptr_q      (ptr_q)
    );

    assign fetch_addr  = ptr_q;
    assign refill_addr = ptr_q;
    assign fetch_valid = (state_q == SEQ_FETCH);
    assign refill_req  = (state_q == SEQ_REFILL);

endmodule

// File: rtl/uopf_checker.sv
module uopf_checker #(
    parameter int AW       = 32,
    parameter int GRP_STEP = 1
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] start_addr,
    input logic          tc_hit,
    input logic          grp_has_br,
    input logic          redir_valid,
    input logic [AW-1:0] redir_addr,
    input logic          refill_done,
    input logic          fetch_valid,
    input logic [AW-1:0] fetch_addr,
    input logic          refill_req,
    input logic [AW-1:0] refill_addr
);
    localparam logic [AW-1:0] STEP = AW'(GRP_STEP);

    assert_reset_ptr_R1: assert property (@(posedge clk)
        rst |=> (fetch_addr == $past(start_addr)) && fetch_valid && !refill_req);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && tc_hit && !grp_has_br && !redir_valid)
        |=> (fetch_addr == $past(fetch_addr) + STEP));

    assert_fetch_refill_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(fetch_valid && refill_req));

    assert_miss_request_R5: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !tc_hit && !redir_valid)
        |=> (refill_req && (refill_addr == $past(fetch_addr))));

    assert_refill_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (refill_req && !refill_done && !redir_valid)
        |=> (refill_req && $stable(refill_addr)));

    assert_refill_resume_R5: assert property (@(posedge clk) disable iff (rst)
        (refill_req && refill_done && !redir_valid)
        |=> (fetch_valid && (fetch_addr == $past(refill_addr))));

    assert_redirect_wins_R6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (fetch_valid && (fetch_addr == $past(redir_addr))));

endmodule

bind uop_fetch_seq uopf_checker #(.AW(AW), .GRP_STEP(GRP_STEP)) u_uopf_chk (
    .clk         (clk),
    .rst         (rst),
    .start_addr  (start_addr),
    .tc_hit      (tc_hit),
    .grp_has_br  (grp_has_br),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .refill_done (refill_done),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .refill_req  (refill_req),
    .refill_addr (refill_addr)
);

// File: tb/tb_uop_fetch_seq.sv
module tb_uop_fetch_seq;
    localparam int AW    = 12;
    localparam int NENT  = 4;
    localparam int STEP  = 2;
    localparam int IW    = 2;
    localparam logic [AW-1:0] START = 12'h100;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] start_addr;
    logic          tc_hit, grp_has_br, res_valid, res_taken, redir_valid, refill_done;
    logic [AW-1:0] grp_br_addr, res_addr, res_target, redir_addr;
    logic          fetch_valid, refill_req;
    logic [AW-1:0] fetch_addr, refill_addr;

    int tests = 0;
    int fails = 0;

    // bench model
    logic          m_v   [NENT];
    logic [AW-1:0] m_tag [NENT];
    logic [AW-1:0] m_tgt [NENT];
    int            m_ctr [NENT];
    string         m_how [NENT];
    logic [AW-1:0] m_ptr;
    logic          m_wait;
    string         why;

    always #5 clk = ~clk;

    uop_fetch_seq #(.AW(AW), .ENTRIES(NENT), .GRP_STEP(STEP)) dut (
        .clk(clk), .rst(rst), .start_addr(start_addr),
        .tc_hit(tc_hit), .grp_has_br(grp_has_br), .grp_br_addr(grp_br_addr),
        .res_valid(res_valid), .res_addr(res_addr), .res_target(res_target),
        .res_taken(res_taken), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .refill_done(refill_done), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .refill_req(refill_req), .refill_addr(refill_addr)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int idx_of(logic [AW-1:0] a);
        return int'(a[IW-1:0]);
    endfunction

    function automatic logic [AW-1:0] tag_of(logic [AW-1:0] a);
        return a >> IW;
    endfunction

    task automatic check_outputs();
        chk(32'(fetch_valid), 32'(!m_wait), why, "fetch_valid");
        chk(32'(refill_req),  32'(m_wait),  why, "refill_req");
        chk(32'(fetch_addr),  32'(m_ptr),   why, "fetch_addr");
        if (m_wait) chk(32'(refill_addr), 32'(m_ptr), why, "refill_addr");
    endtask

    // drive one cycle of inputs at negedge, advance model, wait for next negedge, check
    task automatic cyc(input logic hit, input logic br, input logic [AW-1:0] ba,
                       input logic rv, input logic [AW-1:0] ra, input logic [AW-1:0] rt,
                       input logic rtk, input logic dv, input logic [AW-1:0] da,
                       input logic done);
        int i;
        logic ehit;
        tc_hit = hit; grp_has_br = br; grp_br_addr = ba;
        res_valid = rv; res_addr = ra; res_target = rt; res_taken = rtk;
        redir_valid = dv; redir_addr = da; refill_done = done;
        i = idx_of(ba);
        ehit = m_v[i] && (m_tag[i] == tag_of(ba));
        if (dv) begin
            m_ptr = da; m_wait = 1'b0; why = "R6";
        end else if (!m_wait) begin
            if (!hit) begin
                m_wait = 1'b1; why = "R5";
            end else if (br && ehit && m_ctr[i] >= 2) begin
                m_ptr = m_tgt[i]; why = {"R3 ", m_how[i]};
            end else if (br) begin
                m_ptr = m_ptr + AW'(STEP);
                why = ehit ? {"R4 ", m_how[i]} : {"R4 miss R1 ", m_how[i]};
            end else begin
                m_ptr = m_ptr + AW'(STEP); why = "R2";
            end
        end else begin
            if (done) m_wait = 1'b0;
            why = "R5 R10";
        end
        if (rv) begin
            int j;
            j = idx_of(ra);
            if (m_v[j] && m_tag[j] == tag_of(ra)) begin
                if (rtk) begin
                    m_ctr[j] = (m_ctr[j] == 3) ? 3 : m_ctr[j] + 1;
                    m_tgt[j] = rt;
                end else begin
                    m_ctr[j] = (m_ctr[j] == 0) ? 0 : m_ctr[j] - 1;
                end
                m_how[j] = "R8";
            end else begin
                m_how[j] = m_v[j] ? "R7 R9" : "R7";
                m_v[j] = 1'b1; m_tag[j] = tag_of(ra); m_tgt[j] = rt;
                m_ctr[j] = rtk ? 2 : 1;
            end
        end
        @(negedge clk);
        check_outputs();
    endtask

    task automatic fetch_plain();
        cyc(1, 0, '0, 0, '0, '0, 0, 0, '0, 0);
    endtask

    task automatic fetch_br(input logic [AW-1:0] ba);
        cyc(1, 1, ba, 0, '0, '0, 0, 0, '0, 0);
    endtask

    task automatic resolve(input logic [AW-1:0] ra, input logic [AW-1:0] rt, input logic tk);
        cyc(1, 0, '0, 1, ra, rt, tk, 0, '0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_addr = START;
        tc_hit = 0; grp_has_br = 0; grp_br_addr = '0; res_valid = 0; res_addr = '0;
        res_target = '0; res_taken = 0; redir_valid = 0; redir_addr = '0; refill_done = 0;
        for (int k = 0; k < NENT; k++) begin
            m_v[k] = 0; m_tag[k] = '0; m_tgt[k] = '0; m_ctr[k] = 0; m_how[k] = "R1";
        end
        m_ptr = START; m_wait = 1'b0; why = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_outputs();                            // R1 reset state

        // directed corner cases
        fetch_br(12'h045);                          // R1/R4: empty buffer, sequential
        resolve(12'h045, 12'h300, 1);               // R7 allocate taken, conf 2
        fetch_br(12'h045);                          // R3 jump to 300
        resolve(12'h045, 12'h3A0, 0);               // R8 conf 1, target kept
        fetch_br(12'h045);                          // R4 not taken
        resolve(12'h045, 12'h320, 1);               // R8 conf 2, target 320
        resolve(12'h045, 12'h320, 1);               // conf 3
        resolve(12'h045, 12'h320, 1);               // saturate 3
        resolve(12'h045, 12'h320, 0);               // conf 2
        fetch_br(12'h045);                          // R3 still taken, to 320
        resolve(12'h045, 12'h320, 0);               // conf 1
        resolve(12'h045, 12'h320, 0);               // conf 0
        resolve(12'h045, 12'h320, 0);               // saturate 0
        resolve(12'h045, 12'h320, 1);               // conf 1
        fetch_br(12'h045);                          // R4
        resolve(12'h0A5, 12'h500, 1);               // R9 same index, other tag
        fetch_br(12'h045);                          // R9: old tag gone, sequential
        fetch_br(12'h0A5);                          // R3 to 500
        resolve(12'h011, 12'h222, 0);               // R7 not-taken allocate conf 1
        fetch_br(12'h011);                          // R4
        // miss and refill with noise on ignored inputs
        cyc(0, 0, '0, 0, '0, '0, 0, 0, '0, 0);      // R5
        cyc(1, 1, 12'h0A5, 0, '0, '0, 0, 0, '0, 0); // R10 ignored
        cyc(0, 1, 12'h0A5, 1, 12'h011, 12'h240, 1, 0, '0, 0); // R10 training continues
        cyc(1, 0, '0, 0, '0, '0, 0, 0, '0, 1);      // R5 refill done
        fetch_br(12'h011);                          // R3 via training during refill
        // redirect cancels refill
        cyc(0, 0, '0, 0, '0, '0, 0, 0, '0, 0);
        cyc(1, 0, '0, 0, '0, '0, 0, 1, 12'h7F0, 0); // R6
        // redirect beats a miss in the same cycle, then wrap
        cyc(0, 1, 12'h0A5, 0, '0, '0, 0, 1, 12'hFFE, 0); // R6
        fetch_plain();                              // R2 wraps to 000
        fetch_plain();

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] ba, ra;
            ba = {8'($urandom_range(0, 2)), 2'b00, 2'($urandom_range(0, 3))};
            ra = {8'($urandom_range(0, 2)), 2'b00, 2'($urandom_range(0, 3))};
            cyc(($urandom_range(0, 99) < 85), $urandom_range(0, 1) == 1, ba,
                ($urandom_range(0, 99) < 40), ra, AW'($urandom), ($urandom_range(0, 99) < 70),
                ($urandom_range(0, 99) < 4), AW'($urandom),
                ($urandom_range(0, 99) < 30));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule